// File: doc/BRIEF.md
# Clock Source Mode State Controller

This block is the control heart of a differential clock source. It watches an active-low power-down input, an active-low clock-halt input, two output-mode bits and two multiplier-select bits. From them it picks one of three power states (powered down, halted, running) and tells the output stage which source to drive: the phase-aligned clock, the raw PLL clock, the reference clock, a ground level, or a released (high-impedance) output. It also decodes the multiplier bits into the PLL feedback and prescale divider values.

Every state change and every multiplier change while powered leaves the output unsettled for a bounded time. The block times each interval by counting pulses of a reference tick. A `settled` flag drops on the change and rises again when the interval runs out. The interval limits are compile-time parameters. By default they are derived from the tick period: 3 ms to leave power-down, 1 ms to enter it, 1 ms after a multiplier change, 5 ns to halt, and twenty output cycles to resume after a halt.

Top module: `clkmode_ctrl`

## Requirements
- R1: While `pd_n` is low, `src_sel` reads 0 (ground) and `drv_en` reads 1 from the next clock on, whatever `halt_n` does.
- R2: With `pd_n` high and `halt_n` low, `src_sel` reads 1 (halted) and `drv_en` reads 0 from the next clock on.
- R3: With both `pd_n` and `halt_n` high, the latched mode picks the source: mode 00 gives `src_sel` 2 (aligned), 01 gives 3 (high-impedance, `drv_en` 0), 10 gives 4 (PLL), and 11 gives 5 (reference). Every source other than 1 and 3 drives `drv_en` high.
- R4: The mode bits are captured only on clocks where `pd_n` is low. A change at any other time has no effect on `src_sel`.
- R5: Multiplier code {rsel[1],rsel[0]} decodes to feedback/prescale as 00→9/2, 01→16/3, 10→6/1, 11→8/1. With parameter `ALT_LOW_RATIO` set, code 00 gives 4/1 instead.
- R6: The multiplier bits are registered on every clock. `fb_div` and `pre_div` follow the new code one clock after it is applied.
- R7: On every power-state change, `settled` is low from the next clock on.
- R8: Leaving power-down for any powered state reloads the timer with `T_UP_TICKS`.
- R9: Entering power-down loads `T_DN_TICKS`.
- R10: Running to halted loads `T_OFF_TICKS`, and halted to running loads `T_ON_TICKS`.
- R11: A multiplier change while `pd_n` is high loads `T_MULT_TICKS`. A multiplier change while powered down leaves `settled` unchanged.
- R12: When a state change and a multiplier change fall on the same clock, the timer loads the larger of the two limits.
- R13: The timer advances only on clocks where `tick` is high. `settled` rises on the clock whose tick takes the timer from 1 to 0, so it reads high exactly N tick-clocks after the loading clock for a limit of N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Reference tick pulse that advances the settle timer |
| pd_n | input | 1 | Active-low power-down request |
| halt_n | input | 1 | Active-low clock halt request |
| msel | input | 2 | Output mode bits, captured only while powered down |
| rsel | input | 2 | Multiplier select code |
| src_sel | output | 3 | Output source code (0 ground, 1 halted, 2 aligned, 3 high-Z, 4 PLL, 5 reference) |
| drv_en | output | 1 | Output driver enable |
| settled | output | 1 | High when no settle interval is running |
| fb_div | output | 5 | PLL feedback divider value |
| pre_div | output | 2 | PLL prescale divider value |

## Verification
The coincidence that matters is a halt release and a multiplier change landing on the same clock, because each loads its own settle limit into a single timer. The bench first holds the clock halted until it has settled. On one falling edge it then raises `halt_n` and changes `rsel` together. It sets the multiplier limit larger than the resume limit, then samples `settled` at the clock count of the larger limit and one clock later. An early rise at the resume count exposes a design that lets either event overwrite the other.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;

    typedef enum logic [1:0] {
        ST_PD   = 2'd0,
        ST_STOP = 2'd1,
        ST_RUN  = 2'd2
    } pwr_st_e;

    typedef enum logic [2:0] {
        SRC_GND   = 3'd0,
        SRC_OFF   = 3'd1,
        SRC_ALIGN = 3'd2,
        SRC_HIZ   = 3'd3,
        SRC_PLL   = 3'd4,
        SRC_REF   = 3'd5
    } src_e;

endpackage

// File: rtl/clkmode_ratio_dec.sv
module clkmode_ratio_dec #(
    parameter bit ALT_LOW_RATIO = 1'b0
) (
    input  logic [1:0] code,
    output logic [4:0] fb_div,
    output logic [1:0] pre_div
);
    logic [4:0] low_fb;
    logic [1:0] low_pre;

    // the lowest code is the only entry that differs between variants
    generate
        if (ALT_LOW_RATIO) begin : g_low4
            assign low_fb  = 5'd4;
            assign low_pre = 2'd1;
        end else begin : g_low4p5
            assign low_fb  = 5'd9;
            assign low_pre = 2'd2;
        end
    endgenerate

    always_comb begin
        unique case (code)
            2'b00: begin fb_div = low_fb; pre_div = low_pre; end
            2'b01: begin fb_div = 5'd16;  pre_div = 2'd3;    end
            2'b10: begin fb_div = 5'd6;   pre_div = 2'd1;    end
            default: begin fb_div = 5'd8; pre_div = 2'd1;    end
        endcase
    end
endmodule

// File: rtl/clkmode_src_map.sv
module clkmode_src_map
    import clkmode_pkg::*;
(
    input  pwr_st_e    st,
    input  logic [1:0] mode,
    output logic [2:0] src_sel,
    output logic       drv_en
);
    src_e src;

    always_comb begin
        unique case (st)
            ST_PD:   src = SRC_GND;
            ST_STOP: src = SRC_OFF;
            default: begin
                unique case (mode)
                    2'b00:   src = SRC_ALIGN;
                    2'b01:   src = SRC_HIZ;
                    2'b10:   src = SRC_PLL;
                    default: src = SRC_REF;
                endcase
            end
        endcase
        src_sel = src;
        drv_en  = (src != SRC_OFF) && (src != SRC_HIZ);
    end
endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
    import clkmode_pkg::*;
#(
    parameter int unsigned TICK_NS       = 100,
    parameter int unsigned OUT_PS        = 3750,
    parameter int unsigned SETTLE_CYC    = 20,
    parameter int unsigned T_UP_TICKS    = (3_000_000 + TICK_NS - 1) / TICK_NS,
    parameter int unsigned T_DN_TICKS    = (1_000_000 + TICK_NS - 1) / TICK_NS,
    parameter int unsigned T_MULT_TICKS  = (1_000_000 + TICK_NS - 1) / TICK_NS,
    parameter int unsigned T_OFF_TICKS   = (5 + TICK_NS - 1) / TICK_NS,
    parameter int unsigned T_ON_TICKS    =
        (SETTLE_CYC * OUT_PS + TICK_NS * 1000 - 1) / (TICK_NS * 1000),
    parameter bit          ALT_LOW_RATIO = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       pd_n,
    input  logic       halt_n,
    input  logic [1:0] msel,
    input  logic [1:0] rsel,
    output logic [2:0] src_sel,
    output logic       drv_en,
    output logic       settled,
    output logic [4:0] fb_div,
    output logic [1:0] pre_div
);
    localparam int unsigned M1 = (T_UP_TICKS > T_DN_TICKS) ? T_UP_TICKS : T_DN_TICKS;
    localparam int unsigned M2 = (M1 > T_MULT_TICKS) ? M1 : T_MULT_TICKS;
    localparam int unsigned M3 = (M2 > T_OFF_TICKS) ? M2 : T_OFF_TICKS;
    localparam int unsigned LIM_MAX = (M3 > T_ON_TICKS) ? M3 : T_ON_TICKS;
    localparam int unsigned TW = $clog2(LIM_MAX + 1);

    localparam logic [TW-1:0] L_UP   = TW'(T_UP_TICKS);
    localparam logic [TW-1:0] L_DN   = TW'(T_DN_TICKS);
    localparam logic [TW-1:0] L_MULT = TW'(T_MULT_TICKS);
    localparam logic [TW-1:0] L_OFF  = TW'(T_OFF_TICKS);
    localparam logic [TW-1:0] L_ON   = TW'(T_ON_TICKS);

    typedef struct packed {
        pwr_st_e       st;
        logic [1:0]    mode;
        logic [1:0]    rsel;
        logic [TW-1:0] timer;
        logic          settled;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    pwr_st_e       tgt;
    logic [TW-1:0] trans_lim, mult_lim, load_lim;
    logic          load_w;

    always_comb begin
        ctl_d = ctl_q;

        // power-down dominates, then halt
        if (!pd_n)        tgt = ST_PD;
        else if (!halt_n) tgt = ST_STOP;
        else              tgt = ST_RUN;

        if (tgt == ctl_q.st)      trans_lim = '0;
        else if (tgt == ST_PD)    trans_lim = L_DN;
        else if (ctl_q.st == ST_PD) trans_lim = L_UP;
        else if (tgt == ST_STOP)  trans_lim = L_OFF;
        else                      trans_lim = L_ON;

        mult_lim = (pd_n && (rsel != ctl_q.rsel)) ? L_MULT : '0;
        load_lim = (trans_lim > mult_lim) ? trans_lim : mult_lim;
        load_w   = (load_lim != '0);

        ctl_d.st   = tgt;
        ctl_d.rsel = rsel;
        if (!pd_n) ctl_d.mode = msel;

        if (load_w) begin
            ctl_d.timer   = load_lim;
            ctl_d.settled = 1'b0;
        end else if (tick && (ctl_q.timer != '0)) begin
            ctl_d.timer = ctl_q.timer - 1'b1;
            if (ctl_q.timer == TW'(1)) ctl_d.settled = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_PD, mode: 2'b00, rsel: 2'b00, timer: '0, settled: 1'b1};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign settled = ctl_q.settled;

    clkmode_src_map u_src (
        .st      (ctl_q.st),
        .mode    (ctl_q.mode),
        .src_sel (src_sel),
        .drv_en  (drv_en)
    );

    clkmode_ratio_dec #(.ALT_LOW_RATIO(ALT_LOW_RATIO)) u_ratio (
        .code    (ctl_q.rsel),
        .fb_div  (fb_div),
        .pre_div (pre_div)
    );

    p_pd_gnd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> (src_sel == 3'd0) && drv_en);

    p_halt_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && !halt_n) |=> (src_sel == 3'd1) && !drv_en);

    p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pd_n |=> $stable(ctl_q.mode));

    p_trans_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt != ctl_q.st) |=> !settled);

    p_tick_gate_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_w) |=> (ctl_q.timer == $past(ctl_q.timer)));

    p_rise_on_tick_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(settled) |-> $past(tick));

endmodule

// File: tb/clkmode_ctrl_tb.sv
module clkmode_ctrl_tb;
    localparam int UP = 40, DN = 12, MUL = 30, OFF = 3, ON = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0, tick = 1'b1, pd_n = 1'b0, halt_n = 1'b1;
    logic [1:0] msel = 2'b00, rsel = 2'b00;
    logic [2:0] src_sel;
    logic       drv_en, settled;
    logic [4:0] fb_div, fb_alt;
    logic [1:0] pre_div, pre_alt;
    logic [2:0] src_alt;
    logic       drv_alt, set_alt;
    int         n_vec = 0, n_bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    clkmode_ctrl #(.T_UP_TICKS(UP), .T_DN_TICKS(DN), .T_MULT_TICKS(MUL),
                   .T_OFF_TICKS(OFF), .T_ON_TICKS(ON)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pd_n(pd_n), .halt_n(halt_n),
        .msel(msel), .rsel(rsel), .src_sel(src_sel), .drv_en(drv_en),
        .settled(settled), .fb_div(fb_div), .pre_div(pre_div));

    clkmode_ctrl #(.ALT_LOW_RATIO(1'b1)) u_dut_alt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pd_n(pd_n), .halt_n(halt_n),
        .msel(msel), .rsel(rsel), .src_sel(src_alt), .drv_en(drv_alt),
        .settled(set_alt), .fb_div(fb_alt), .pre_div(pre_alt));

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // called one falling edge after the loading clock
    task automatic expect_settle(input int lim, input string req);
        repeat (lim - 1) @(negedge clk);
        check({req, " settled still low"}, settled, 0);
        @(negedge clk);
        check({req, " settled high"}, settled, 1);
    endtask

    task automatic t_reset;
        check("R1 reset src", src_sel, 0);
        check("R1 reset drv", drv_en, 1);
        check("R13 reset settled", settled, 1);
        check("R5 reset fb", fb_div, 9);
        check("R5 reset pre", pre_div, 2);
        check("R5 alt fb", fb_alt, 4);
        check("R5 alt pre", pre_alt, 1);
    endtask

    task automatic t_ratio;
        int fbx[4]  = '{9, 16, 6, 8};
        int prx[4]  = '{2, 3, 1, 1};
        for (int i = 1; i <= 4; i++) begin
            rsel = 2'(i % 4);
            @(negedge clk);
            check("R5 R6 fb", fb_div, fbx[i % 4]);
            check("R5 R6 pre", pre_div, prx[i % 4]);
            check("R11 no settle in power-down", settled, 1);
        end
    endtask

    task automatic t_pd_exit;
        msel = 2'b10;
        @(negedge clk);
        pd_n = 1'b1; halt_n = 1'b1;
        @(negedge clk);
        check("R3 pll src", src_sel, 4);
        check("R7 drop on exit", settled, 0);
        expect_settle(UP, "R8");
    endtask

    task automatic t_mode_ignore;
        msel = 2'b11;
        repeat (3) @(negedge clk);
        check("R4 mode ignored", src_sel, 4);
        check("R4 settled kept", settled, 1);
    endtask

    task automatic t_halt_cycle;
        halt_n = 1'b0;
        @(negedge clk);
        check("R2 halt src", src_sel, 1);
        check("R2 halt drv", drv_en, 0);
        check("R7 drop on halt", settled, 0);
        expect_settle(OFF, "R10 off");
        halt_n = 1'b1;
        @(negedge clk);
        check("R3 resume src", src_sel, 4);
        expect_settle(ON, "R10 on");
    endtask

    task automatic t_mult;
        rsel = 2'b10;
        @(negedge clk);
        check("R11 drop", settled, 0);
        check("R6 fb", fb_div, 6);
        expect_settle(MUL, "R11");
    endtask

    task automatic t_coincide;
        halt_n = 1'b0;
        @(negedge clk);
        expect_settle(OFF, "R10 off");
        halt_n = 1'b1; rsel = 2'b11;
        @(negedge clk);
        check("R12 drop", settled, 0);
        check("R12 fb", fb_div, 8);
        expect_settle(MUL, "R12 larger limit");
    endtask

    task automatic t_tick_gate;
        halt_n = 1'b0; tick = 1'b0;
        repeat (10) @(negedge clk);
        check("R13 frozen without tick", settled, 0);
        tick = 1'b1;
        repeat (OFF - 1) @(negedge clk);
        check("R13 counting", settled, 0);
        @(negedge clk);
        check("R13 expired", settled, 1);
        halt_n = 1'b1;
        @(negedge clk);
        expect_settle(ON, "R10 on");
    endtask

    task automatic t_pd_enter;
        pd_n = 1'b0; msel = 2'b01;
        @(negedge clk);
        check("R1 pd src", src_sel, 0);
        check("R7 drop on pd", settled, 0);
        expect_settle(DN, "R9");
        halt_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 halt ignored in pd", src_sel, 0);
        check("R1 drv in pd", drv_en, 1);
        halt_n = 1'b1;
        @(negedge clk);
        pd_n = 1'b1;
        @(negedge clk);
        check("R3 hiz src", src_sel, 3);
        check("R3 hiz drv", drv_en, 0);
        expect_settle(UP, "R8");
    endtask

    task automatic t_modes;
        logic [1:0] mv[2] = '{2'b00, 2'b11};
        int         ex[2] = '{2, 5};
        for (int k = 0; k < 2; k++) begin
            pd_n = 1'b0; msel = mv[k];
            repeat (DN + 3) @(negedge clk);
            pd_n = 1'b1;
            @(negedge clk);
            check("R3 mode src", src_sel, ex[k]);
            check("R3 mode drv", drv_en, 1);
            repeat (UP + 3) @(negedge clk);
        end
        pd_n = 1'b0;
        repeat (DN + 3) @(negedge clk);
        pd_n = 1'b1; halt_n = 1'b0;
        @(negedge clk);
        check("R2 pd to halt src", src_sel, 1);
        expect_settle(UP, "R8 to halt");
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ratio();
        t_pd_exit();
        t_mode_ignore();
        t_halt_cycle();
        t_mult();
        t_coincide();
        t_tick_gate();
        t_pd_enter();
        t_modes();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end
endmodule